// File: doc/BRIEF.md
# Constant On-Time PWM Generator

This block produces the high-side switch request for a ripple-regulated buck controller that uses constant on-time control. It receives three sampled comparator flags. The first says the feedback is below the soft-start voltage. The second says the feedback is below the reference. The third says the soft-start voltage is still below the reference. From these it decides when a new on-pulse may begin. No fixed clock sets the pulse rate: a pulse begins only when the feedback has dropped below the active threshold, which is the lower of soft start and reference.

Each pulse is a fixed number of clock cycles long. That number is computed from a programmed count divided by an input-voltage code, so a higher input voltage gives a shorter pulse. After a pulse ends, two blanking windows run side by side. One is a minimum high-side off time. The other is a minimum low-side conduction interval. A new pulse may start only after both have run out. Under a sustained demand, the pulse rate therefore rises to one pulse per on-time plus blanking. A run input stops the block at once and returns every timer to idle.

Top module: `cot_pwm_gen`

## Requirements
- R1: While idle and running, the generator uses `fb_lt_ss` as the start flag when `ss_lt_ref` is 1, and `fb_lt_ref` when `ss_lt_ref` is 0. `pwm_hi` goes high in the clock cycle after the rising edge that samples the selected flag at 1. The unselected flag has no effect.
- R2: Out of reset (`rst_n` = 0 and after its release, with no start flag), `pwm_hi` is 0.
- R3: Each pulse lasts exactly T clock cycles. T = `ton_prog` / `vin_code`, using integer division with the remainder dropped. A `vin_code` of 0 is treated as 1. T is raised to TON_MIN if the quotient is smaller.
- R4: T is captured when the pulse starts. Changes to `ton_prog` or `vin_code` during a pulse do not change that pulse's length.
- R5: After a pulse, `pwm_hi` stays low for at least max(MIN_OFF, MIN_LOW) cycles. With the start flag held at 1, it stays low for exactly that long, so the period is T + max(MIN_OFF, MIN_LOW).
- R6: A start flag that is high only during a pulse or during the blanking window is ignored and not queued: no pulse follows once that window ends.
- R7: When `run` rises with no start flag present, such as a pre-charged output, `pwm_hi` stays low for as long as no flag appears. The first pulse follows the first flag.
- R8: Driving `run` to 0 forces `pwm_hi` low in the same cycle, without waiting for a clock edge. It keeps `pwm_hi` low while `run` is 0 and clears all timers. When `run` returns with a flag present, a full-length pulse starts at the next edge, with no blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Run enable; 0 stops switching at once |
| fb_lt_ss | input | 1 | Feedback below soft-start voltage |
| fb_lt_ref | input | 1 | Feedback below reference |
| ss_lt_ref | input | 1 | Soft-start voltage below reference |
| ton_prog | input | PROG_W | Programmed on-time numerator |
| vin_code | input | VIN_W | Input-voltage code (divisor) |
| pwm_hi | output | 1 | High-side on request |

## Verification
All four combinations of the select flag and the selected flag are driven. This separates choosing the lower threshold from reacting to whichever flag happens to be high. On-time is measured for an exact quotient, a truncated quotient, a zero divisor and a quotient below the floor. It is also measured while the divisor changes mid-pulse, which shows the value is captured rather than tracked live. A held flag measures the off interval on two instances: one where the low-side interval is the longer window and one where the off time is. This shows that the longer of the two governs. Short flag blips inside the pulse and inside the blanking window show that requests are dropped, not queued. Starting with no flag, and dropping `run` mid-pulse, cover the pre-bias and forced-stop cases.

// File: rtl/cot_pkg.sv
// Shared types for the constant on-time PWM generator.
// Assumes nothing beyond a common clock domain for all users.
package cot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_BLANK = 2'd2
    } cot_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cot_trigger_sel.sv
// Start-condition selector: compares feedback against the lower of soft
// start and reference by picking the matching comparator flag.
// Assumes the flags are already synchronous to clk.
module cot_trigger_sel (
    input  logic run,
    input  logic fb_lt_ss,
    input  logic fb_lt_ref,
    input  logic ss_lt_ref,
    output logic start_req
);

    // choose the flag belonging to the lower threshold, gated by run
    always_comb begin
        if (ss_lt_ref) start_req = run & fb_lt_ss;
        else           start_req = run & fb_lt_ref;
    end

endmodule

// File: rtl/cot_ontime_calc.sv
// On-time length calculator: programmed count divided by the input-voltage
// code, with a zero divisor read as one and a floor of TON_MIN cycles.
// Assumes VIN_W < PROG_W and TON_MIN >= 1.
module cot_ontime_calc #(
    parameter int PROG_W  = 12,
    parameter int VIN_W   = 6,
    parameter int TON_MIN = 2
) (
    input  logic [PROG_W-1:0] ton_prog,
    input  logic [VIN_W-1:0]  vin_code,
    output logic [PROG_W-1:0] ton_cycles
);

    logic [PROG_W-1:0] divisor;
    logic [PROG_W-1:0] quot;

    // integer quotient, then clamp to the minimum pulse length
    always_comb begin
        divisor = {{(PROG_W-VIN_W){1'b0}}, vin_code};
        if (vin_code == '0) divisor = PROG_W'(1);
        quot = ton_prog / divisor;
        if (quot < PROG_W'(TON_MIN)) ton_cycles = PROG_W'(TON_MIN);
        else                         ton_cycles = quot;
    end

endmodule

// File: rtl/cot_interval_timer.sv
// Loadable down-counter used for on-time and blanking windows. Loading N-1
// and leaving the state on 'expired' gives a window of exactly N cycles.
// Assumes clear has priority over load.
module cot_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // count down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clear)        cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cot_pwm_gen.sv
// Constant on-time PWM generator top. Idle -> on (T cycles) -> blank
// (both minimum off and minimum low-side windows) -> idle or straight back
// to on when a start flag is present as blanking ends. Start flags are only
// looked at in idle or at the end of blanking; run low clears everything.
// Assumes MIN_OFF >= 1, MIN_LOW >= 1, TON_MIN >= 1, VIN_W < PROG_W.
module cot_pwm_gen
    import cot_pkg::*;
#(
    parameter int PROG_W  = 12,
    parameter int VIN_W   = 6,
    parameter int TON_MIN = 2,
    parameter int MIN_OFF = 6,
    parameter int MIN_LOW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fb_lt_ss,
    input  logic              fb_lt_ref,
    input  logic              ss_lt_ref,
    input  logic [PROG_W-1:0] ton_prog,
    input  logic [VIN_W-1:0]  vin_code,
    output logic              pwm_hi
);

    localparam int BLANK_MAX = max_of(MIN_OFF, MIN_LOW);
    localparam int BL_W      = $clog2(BLANK_MAX + 1);
    localparam logic [BL_W-1:0] OFF_LOAD = BL_W'(MIN_OFF - 1);
    localparam logic [BL_W-1:0] LOW_LOAD = BL_W'(MIN_LOW - 1);

    cot_state_e        state, state_n;
    logic              start_req;
    logic [PROG_W-1:0] ton_cycles;
    logic              load_on, load_blank;
    logic              on_done, off_done, low_done;

    cot_trigger_sel u_sel (
        .run       (run),
        .fb_lt_ss  (fb_lt_ss),
        .fb_lt_ref (fb_lt_ref),
        .ss_lt_ref (ss_lt_ref),
        .start_req (start_req)
    );

    cot_ontime_calc #(
        .PROG_W  (PROG_W),
        .VIN_W   (VIN_W),
        .TON_MIN (TON_MIN)
    ) u_calc (
        .ton_prog   (ton_prog),
        .vin_code   (vin_code),
        .ton_cycles (ton_cycles)
    );

    cot_interval_timer #(.W(PROG_W)) u_on_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .load     (load_on),
        .load_val (ton_cycles - PROG_W'(1)),
        .expired  (on_done)
    );

    cot_interval_timer #(.W(BL_W)) u_off_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .load     (load_blank),
        .load_val (OFF_LOAD),
        .expired  (off_done)
    );

    cot_interval_timer #(.W(BL_W)) u_low_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .load     (load_blank),
        .load_val (LOW_LOAD),
        .expired  (low_done)
    );

    // next-state and timer-load decisions
    always_comb begin
        state_n    = state;
        load_on    = 1'b0;
        load_blank = 1'b0;
        if (!run) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state_n = ST_ON;
                        load_on = 1'b1;
                    end
                end
                ST_ON: begin
                    if (on_done) begin
                        state_n    = ST_BLANK;
                        load_blank = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (off_done && low_done) begin
                        if (start_req) begin
                            state_n = ST_ON;
                            load_on = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // run gates the output without waiting for an edge
    assign pwm_hi = (state == ST_ON) && run;

endmodule

// File: rtl/cot_pwm_gen_chk.sv
// Port-level checker for cot_pwm_gen: start causality, blanking length,
// pulse floor and clean restart. Bound to every instance of the top.
// Assumes the same parameter values as the bound instance.
module cot_pwm_gen_chk #(
    parameter int TON_MIN = 2,
    parameter int MIN_OFF = 6,
    parameter int MIN_LOW = 10
) (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic fb_lt_ss,
    input logic fb_lt_ref,
    input logic ss_lt_ref,
    input logic pwm_hi
);

    localparam int BLANK_LEN = (MIN_OFF > MIN_LOW) ? MIN_OFF : MIN_LOW;

    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    // length of the current high run and of the low run since the last pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= 16'hFFFF;
        end else begin
            if (pwm_hi) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
            else        hi_cnt <= '0;
            if (!run)                     lo_cnt <= 16'hFFFF;
            else if (pwm_hi)              lo_cnt <= '0;
            else if (lo_cnt != 16'hFFFF)  lo_cnt <= lo_cnt + 16'd1;
        end
    end

    assert_start_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_hi) |-> $past(ss_lt_ref ? fb_lt_ss : fb_lt_ref));

    assert_blank_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_hi) |-> (lo_cnt >= 16'(BLANK_LEN)));

    assert_pulse_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_hi) && run && $past(run)) |-> (hi_cnt >= 16'(TON_MIN)));

    assert_clean_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !pwm_hi);

endmodule

bind cot_pwm_gen cot_pwm_gen_chk #(
    .TON_MIN (TON_MIN),
    .MIN_OFF (MIN_OFF),
    .MIN_LOW (MIN_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .fb_lt_ss  (fb_lt_ss),
    .fb_lt_ref (fb_lt_ref),
    .ss_lt_ref (ss_lt_ref),
    .pwm_hi    (pwm_hi)
);

// File: tb/tb_cot_pwm_gen.sv
// Directed bench for cot_pwm_gen; one task per scenario.
module tb_cot_pwm_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        fb_lt_ss, fb_lt_ref, ss_lt_ref;
    logic [11:0] ton_prog;
    logic [5:0]  vin_code;
    logic        pwm, pwm_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cot_pwm_gen #(.PROG_W(12), .VIN_W(6), .TON_MIN(2), .MIN_OFF(6), .MIN_LOW(10)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .fb_lt_ss(fb_lt_ss),
        .fb_lt_ref(fb_lt_ref), .ss_lt_ref(ss_lt_ref),
        .ton_prog(ton_prog), .vin_code(vin_code), .pwm_hi(pwm));

    cot_pwm_gen #(.PROG_W(12), .VIN_W(6), .TON_MIN(2), .MIN_OFF(12), .MIN_LOW(4)) dut_b (
        .clk(clk), .rst_n(rst_n), .run(run), .fb_lt_ss(fb_lt_ss),
        .fb_lt_ref(fb_lt_ref), .ss_lt_ref(ss_lt_ref),
        .ton_prog(ton_prog), .vin_code(vin_code), .pwm_hi(pwm_b));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_trig(input logic v);
        ss_lt_ref = 1'b0;
        fb_lt_ss  = 1'b0;
        fb_lt_ref = v;
    endtask

    task automatic settle();
        set_trig(1'b0);
        repeat (200) @(negedge clk);
    endtask

    // wait for a pulse on the chosen output, then measure high and low runs
    task automatic measure(input bit sel_b, output int hi, output int lo);
        int t = 0;
        while (!(sel_b ? pwm_b : pwm) && t < 2000) begin t++; @(negedge clk); end
        hi = 0;
        while ((sel_b ? pwm_b : pwm) && hi < 5000) begin hi++; @(negedge clk); end
        lo = 0;
        while (!(sel_b ? pwm_b : pwm) && lo < 300) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run = 1'b1; set_trig(1'b0);
        ton_prog = 12'd120; vin_code = 6'd8;
        repeat (3) @(negedge clk);
        check("R2 pwm in reset", int'(pwm), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 pwm after reset", int'(pwm), 0);
    endtask

    task automatic t_select();
        // {ss_lt_ref, fb_lt_ss, fb_lt_ref} -> expected start
        logic [2:0] pat [4] = '{3'b110, 3'b101, 3'b001, 3'b010};
        int         exp [4] = '{1, 0, 1, 0};
        for (int i = 0; i < 4; i++) begin
            settle();
            ss_lt_ref = pat[i][2]; fb_lt_ss = pat[i][1]; fb_lt_ref = pat[i][0];
            @(negedge clk);
            check($sformatf("R1 select pattern %0d", i), int'(pwm), exp[i]);
        end
    endtask

    task automatic pulse_once(input int exp, input string tag);
        int hi;
        settle();
        set_trig(1'b1);
        @(negedge clk);
        check({"R1 latency ", tag}, int'(pwm), 1);
        set_trig(1'b0);
        hi = 0;
        while (pwm && hi < 5000) begin hi++; @(negedge clk); end
        check({"R3 on-time ", tag}, hi, exp);
    endtask

    task automatic t_ontime();
        ton_prog = 12'd120; vin_code = 6'd8; pulse_once(15, "120/8");
        ton_prog = 12'd100; vin_code = 6'd7; pulse_once(14, "100/7");
        ton_prog = 12'd40;  vin_code = 6'd0; pulse_once(40, "40/0");
        ton_prog = 12'd3;   vin_code = 6'd5; pulse_once(2,  "3/5 floor");
        ton_prog = 12'd120; vin_code = 6'd8;
    endtask

    task automatic t_latch();
        int hi;
        settle();
        set_trig(1'b1);
        @(negedge clk);
        set_trig(1'b0);
        vin_code = 6'd2; ton_prog = 12'd10;
        hi = 1;
        @(negedge clk);
        while (pwm && hi < 5000) begin hi++; @(negedge clk); end
        check("R4 on-time captured at start", hi, 15);
        ton_prog = 12'd120; vin_code = 6'd8;
    endtask

    task automatic t_blank();
        int hi, lo;
        settle();
        set_trig(1'b1);
        measure(1'b0, hi, lo);
        measure(1'b0, hi, lo);
        check("R5 held flag high run", hi, 15);
        check("R5 held flag low run MIN_LOW longer", lo, 10);
        measure(1'b1, hi, lo);
        measure(1'b1, hi, lo);
        check("R5 held flag low run MIN_OFF longer", lo, 12);
        set_trig(1'b0);
    endtask

    task automatic t_ignore();
        int highs = 0;
        settle();
        set_trig(1'b1);
        @(negedge clk);
        set_trig(1'b0);
        repeat (4) @(negedge clk);
        set_trig(1'b1);
        @(negedge clk);
        set_trig(1'b0);
        while (pwm) @(negedge clk);
        repeat (2) @(negedge clk);
        set_trig(1'b1);
        @(negedge clk);
        set_trig(1'b0);
        for (int i = 0; i < 40; i++) begin
            if (pwm) highs++;
            @(negedge clk);
        end
        check("R6 blips during pulse and blank not queued", highs, 0);
    endtask

    task automatic t_prebias();
        int highs = 0;
        run = 1'b0; set_trig(1'b0);
        repeat (5) @(negedge clk);
        run = 1'b1;
        for (int i = 0; i < 60; i++) begin
            if (pwm) highs++;
            @(negedge clk);
        end
        check("R7 no switching without flag", highs, 0);
        set_trig(1'b1);
        @(negedge clk);
        check("R7 first pulse follows flag", int'(pwm), 1);
        set_trig(1'b0);
    endtask

    task automatic t_run();
        int highs = 0;
        int hi;
        settle();
        set_trig(1'b1);
        @(negedge clk);
        repeat (3) @(negedge clk);
        run = 1'b0;
        #1;
        check("R8 pwm low same cycle as run drop", int'(pwm), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
        check("R8 pwm held low while stopped", highs, 0);
        run = 1'b1;
        @(negedge clk);
        check("R8 restart without blanking", int'(pwm), 1);
        set_trig(1'b0);
        hi = 0;
        while (pwm && hi < 5000) begin hi++; @(negedge clk); end
        check("R8 full pulse after restart", hi, 15);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_select();
        t_ontime();
        t_latch();
        t_blank();
        t_ignore();
        t_prebias();
        t_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule